// File: doc/BRIEF.md
# Coexistence Grant Signal Conditioning

This block sits after a radio coexistence arbiter. It takes the arbiter's grant decision and turns it into the signals other parties see. An external coexistence partner gets an activity flag and a priority flag. The first on-chip MAC gets a radio-busy input and forwarded WLAN transmit and receive indications. The second on-chip MAC gets a clear-channel status. A diagnostic bus can have one 3-bit group replaced with the arbiter's closing sub-state and decision. The arbitration itself is computed elsewhere.

A single register stage captures every input on each rising clock edge. Inside that stage the decision is held as a four-state grant machine with the states GR_NONE, GR_MAC_A, GR_MAC_B and GR_FOREIGN. Each edge moves the machine straight to the state named by the incoming decision code: code 0 goes to GR_NONE, 1 to GR_MAC_A, 2 to GR_MAC_B and 3 to GR_FOREIGN. Any state can reach any other state in one edge. All outputs are derived from the registered state and the registered inputs, so every output has exactly one cycle of latency and cannot glitch.

Top module: `coex_grant_cond`

## Requirements
- R1: While rst_n is low, every output is 0, whatever the inputs are.
- R2: With act_mode = 0, partner_act is act_a OR act_b, for every decision code (0 none, 1 MAC A, 2 MAC B, 3 foreign).
- R3: With act_mode = 1, partner_act is 0 when the decision is 3 (foreign). For codes 0, 1 and 2 it follows R2.
- R4: partner_pri is 1 only when the decision is 1 or 2 and win_hi_pri is 1. It is 0 for decision 0 (none) and for decision 3.
- R5: a_busy follows busy_sel. Value 0 gives (decision==1) AND rf_busy. Value 1 gives constant 0. Value 2 gives (decision==2 OR decision==3) OR rf_busy. Value 3 gives (decision==2 OR decision==3).
- R6: With cca_force = 1 and a decision other than 2, b_cca is 1. In every other case b_cca equals cca_raw.
- R7: With wlan_fwd = 1, a_wlan_tx and a_wlan_rx follow wlan_tx_in and wlan_rx_in. With wlan_fwd = 0, both are 0.
- R8: With diag_sel = 1, diag_out[2:0] is {closing, decision[1:0]}. All other bits equal diag_in.
- R9: With diag_sel = 2, diag_out[5:3] is {closing, decision[1:0]}, and the other bits equal diag_in. With diag_sel = 0 or 3, diag_out equals diag_in.
- R10: Each output reflects the inputs as sampled at the previous rising clock edge. Changing an input between edges does not move any output until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_code | input | 2 | Arbiter decision: 0 none, 1 MAC A, 2 MAC B, 3 foreign |
| closing | input | 1 | Arbiter closing sub-state |
| act_a | input | 1 | MAC A active (already masked) |
| act_b | input | 1 | MAC B active (already masked) |
| win_hi_pri | input | 1 | Winning table entry is high priority |
| rf_busy | input | 1 | Radio busy from RF controller |
| cca_raw | input | 1 | Clear-channel status from the radio |
| wlan_tx_in | input | 1 | WLAN transmit indication |
| wlan_rx_in | input | 1 | WLAN receive indication |
| act_mode | input | 1 | Partner activity mode |
| busy_sel | input | 2 | Radio-busy source select |
| cca_force | input | 1 | Force CCA to 1 when MAC B lacks the grant |
| wlan_fwd | input | 1 | Forward WLAN indications to MAC A |
| diag_sel | input | 2 | Diagnostic overlay select |
| diag_in | input | DIAG_W | Incoming diagnostic bus |
| partner_act | output | 1 | Activity flag to the external partner |
| partner_pri | output | 1 | Priority flag to the external partner |
| a_busy | output | 1 | Radio-busy input of MAC A |
| b_cca | output | 1 | CCA status input of MAC B |
| a_wlan_tx | output | 1 | WLAN transmit input of MAC A |
| a_wlan_rx | output | 1 | WLAN receive input of MAC A |
| diag_out | output | DIAG_W | Diagnostic bus after the overlay |

## Verification
The hardest cases to reach are the ones where a setting depends on who holds the grant. Examples are busy select 0 under the foreign grant, or the CCA force while MAC B holds the grant. A single fixed decision never exposes them. Each scenario therefore sweeps all four decision codes against every relevant control value and data level, and compares each result with a model written from the requirements. For the latency requirement, the bench changes the inputs between edges and confirms the outputs hold until the next edge.

// File: rtl/coex_cond_pkg.sv
package coex_cond_pkg;

    typedef enum logic [1:0] {
        GR_NONE    = 2'd0,
        GR_MAC_A   = 2'd1,
        GR_MAC_B   = 2'd2,
        GR_FOREIGN = 2'd3
    } grant_e;

    typedef enum logic [1:0] {
        BSY_OWN_AND_RF  = 2'd0,
        BSY_HOLD_LOW    = 2'd1,
        BSY_OTHER_OR_RF = 2'd2,
        BSY_OTHER_ONLY  = 2'd3
    } busy_sel_e;

    typedef struct packed {
        logic act_a;
        logic act_b;
        logic hi_pri;
        logic rf_busy;
        logic cca_raw;
        logic wlan_tx;
        logic wlan_rx;
        logic closing;
    } samp_t;

    typedef struct packed {
        logic      act_mode;
        busy_sel_e busy_sel;
        logic      cca_force;
        logic      wlan_fwd;
        logic [1:0] diag_sel;
    } cfg_t;

endpackage

// File: rtl/coex_cond_stage.sv
module coex_cond_stage
    import coex_cond_pkg::*;
#(
    parameter int DIAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        dec_code,
    input  samp_t             samp_in,
    input  cfg_t              cfg_in,
    input  logic [DIAG_W-1:0] diag_in,
    output grant_e            state,
    output samp_t             samp_q,
    output cfg_t              cfg_q,
    output logic [DIAG_W-1:0] diag_q
);

    grant_e state_nxt;

    // Next grant state: every edge jumps to the state named by the decision.
    always_comb begin
        unique case (dec_code)
            2'd0:    state_nxt = GR_NONE;
            2'd1:    state_nxt = GR_MAC_A;
            2'd2:    state_nxt = GR_MAC_B;
            default: state_nxt = GR_FOREIGN;
        endcase
    end

    // State register together with the sampled companions.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= GR_NONE;
            samp_q <= '0;
            cfg_q  <= '0;
            diag_q <= '0;
        end else begin
            state  <= state_nxt;
            samp_q <= samp_in;
            cfg_q  <= cfg_in;
            diag_q <= diag_in;
        end
    end

    // R10: the registered state tracks the previous decision code.
    a_r10_state_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_code == 2'd3) |=> (state == GR_FOREIGN));

endmodule

// File: rtl/coex_cond_radio.sv
module coex_cond_radio
    import coex_cond_pkg::*;
(
    input  grant_e state,
    input  samp_t  samp_q,
    input  cfg_t   cfg_q,
    output logic   partner_act,
    output logic   partner_pri,
    output logic   a_busy,
    output logic   b_cca,
    output logic   a_wlan_tx,
    output logic   a_wlan_rx
);

    logic own_grant;
    logic other_grant;
    logic any_active;

    // Output process driven from the grant state and the sampled inputs.
    always_comb begin
        own_grant   = 1'b0;
        other_grant = 1'b0;
        any_active  = samp_q.act_a | samp_q.act_b;
        partner_act = any_active;
        partner_pri = 1'b0;
        unique case (state)
            GR_NONE: begin
                partner_pri = 1'b0;
            end
            GR_MAC_A: begin
                own_grant   = 1'b1;
                partner_pri = samp_q.hi_pri;
            end
            GR_MAC_B: begin
                other_grant = 1'b1;
                partner_pri = samp_q.hi_pri;
            end
            GR_FOREIGN: begin
                other_grant = 1'b1;
                if (cfg_q.act_mode) partner_act = 1'b0;
            end
        endcase

        unique case (cfg_q.busy_sel)
            BSY_OWN_AND_RF:  a_busy = own_grant & samp_q.rf_busy;
            BSY_HOLD_LOW:    a_busy = 1'b0;
            BSY_OTHER_OR_RF: a_busy = other_grant | samp_q.rf_busy;
            BSY_OTHER_ONLY:  a_busy = other_grant;
        endcase

        b_cca     = (cfg_q.cca_force && state != GR_MAC_B) ? 1'b1 : samp_q.cca_raw;
        a_wlan_tx = cfg_q.wlan_fwd & samp_q.wlan_tx;
        a_wlan_rx = cfg_q.wlan_fwd & samp_q.wlan_rx;
    end

endmodule

// File: rtl/coex_cond_diag.sv
module coex_cond_diag
    import coex_cond_pkg::*;
#(
    parameter int DIAG_W = 8,
    parameter int GRP_W  = 3,
    parameter int N_GRP  = 2
) (
    input  grant_e            state,
    input  logic              closing,
    input  logic [1:0]        diag_sel,
    input  logic [DIAG_W-1:0] diag_q,
    output logic [DIAG_W-1:0] diag_out
);

    localparam int OVL_W = GRP_W * N_GRP;

    logic [GRP_W-1:0] status_grp;

    always_comb status_grp = {closing, state};

    // One overlay slot per group; select value g+1 claims group g.
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        assign diag_out[g*GRP_W +: GRP_W] =
            (diag_sel == 2'(g + 1)) ? status_grp : diag_q[g*GRP_W +: GRP_W];
    end

    if (DIAG_W > OVL_W) begin : g_upper
        assign diag_out[DIAG_W-1:OVL_W] = diag_q[DIAG_W-1:OVL_W];
    end

endmodule

// File: rtl/coex_grant_cond.sv
module coex_grant_cond
    import coex_cond_pkg::*;
#(
    parameter int DIAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        dec_code,
    input  logic              closing,
    input  logic              act_a,
    input  logic              act_b,
    input  logic              win_hi_pri,
    input  logic              rf_busy,
    input  logic              cca_raw,
    input  logic              wlan_tx_in,
    input  logic              wlan_rx_in,
    input  logic              act_mode,
    input  logic [1:0]        busy_sel,
    input  logic              cca_force,
    input  logic              wlan_fwd,
    input  logic [1:0]        diag_sel,
    input  logic [DIAG_W-1:0] diag_in,
    output logic              partner_act,
    output logic              partner_pri,
    output logic              a_busy,
    output logic              b_cca,
    output logic              a_wlan_tx,
    output logic              a_wlan_rx,
    output logic [DIAG_W-1:0] diag_out
);

    samp_t             samp_in;
    samp_t             samp_q;
    cfg_t              cfg_in;
    cfg_t              cfg_q;
    grant_e            state;
    logic [DIAG_W-1:0] diag_q;

    always_comb begin
        samp_in.act_a   = act_a;
        samp_in.act_b   = act_b;
        samp_in.hi_pri  = win_hi_pri;
        samp_in.rf_busy = rf_busy;
        samp_in.cca_raw = cca_raw;
        samp_in.wlan_tx = wlan_tx_in;
        samp_in.wlan_rx = wlan_rx_in;
        samp_in.closing = closing;
        cfg_in.act_mode  = act_mode;
        cfg_in.busy_sel  = busy_sel_e'(busy_sel);
        cfg_in.cca_force = cca_force;
        cfg_in.wlan_fwd  = wlan_fwd;
        cfg_in.diag_sel  = diag_sel;
    end

    coex_cond_stage #(.DIAG_W(DIAG_W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .dec_code (dec_code),
        .samp_in  (samp_in),
        .cfg_in   (cfg_in),
        .diag_in  (diag_in),
        .state    (state),
        .samp_q   (samp_q),
        .cfg_q    (cfg_q),
        .diag_q   (diag_q)
    );

    coex_cond_radio u_radio (
        .state       (state),
        .samp_q      (samp_q),
        .cfg_q       (cfg_q),
        .partner_act (partner_act),
        .partner_pri (partner_pri),
        .a_busy      (a_busy),
        .b_cca       (b_cca),
        .a_wlan_tx   (a_wlan_tx),
        .a_wlan_rx   (a_wlan_rx)
    );

    coex_cond_diag #(.DIAG_W(DIAG_W)) u_diag (
        .state    (state),
        .closing  (samp_q.closing),
        .diag_sel (cfg_q.diag_sel),
        .diag_q   (diag_q),
        .diag_out (diag_out)
    );

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!partner_act && !partner_pri && !a_busy && !b_cca && diag_out == '0));

    a_r3_foreign_mutes_act: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode && dec_code == 2'd3) |=> !partner_act);

    a_r4_no_pri_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_code == 2'd0 || dec_code == 2'd3) |=> !partner_pri);

    a_r5_busy_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_sel == 2'd1) |=> !a_busy);

    a_r6_cca_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (cca_force && dec_code != 2'd2) |=> b_cca);

    a_r7_wlan_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        !wlan_fwd |=> (!a_wlan_tx && !a_wlan_rx));

endmodule

// File: tb/coex_grant_cond_test.sv
module coex_grant_cond_test;

    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] dec_code = '0;
    logic closing = 0, act_a = 0, act_b = 0, win_hi_pri = 0, rf_busy = 0;
    logic cca_raw = 0, wlan_tx_in = 0, wlan_rx_in = 0;
    logic act_mode = 0, cca_force = 0, wlan_fwd = 0;
    logic [1:0] busy_sel = '0, diag_sel = '0;
    logic [DW-1:0] diag_in = '0;
    logic partner_act, partner_pri, a_busy, b_cca, a_wlan_tx, a_wlan_rx;
    logic [DW-1:0] diag_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    coex_grant_cond #(.DIAG_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .dec_code(dec_code), .closing(closing),
        .act_a(act_a), .act_b(act_b), .win_hi_pri(win_hi_pri), .rf_busy(rf_busy),
        .cca_raw(cca_raw), .wlan_tx_in(wlan_tx_in), .wlan_rx_in(wlan_rx_in),
        .act_mode(act_mode), .busy_sel(busy_sel), .cca_force(cca_force),
        .wlan_fwd(wlan_fwd), .diag_sel(diag_sel), .diag_in(diag_in),
        .partner_act(partner_act), .partner_pri(partner_pri), .a_busy(a_busy),
        .b_cca(b_cca), .a_wlan_tx(a_wlan_tx), .a_wlan_rx(a_wlan_rx),
        .diag_out(diag_out)
    );

    // Expected values captured from the driven inputs before an edge.
    logic e_act, e_pri, e_busy, e_cca, e_tx, e_rx;
    logic [DW-1:0] e_diag;

    task automatic model();
        logic other;
        other  = (dec_code == 2'd2) || (dec_code == 2'd3);
        e_act  = (act_a | act_b) & ~(act_mode & (dec_code == 2'd3));
        e_pri  = ((dec_code == 2'd1) || (dec_code == 2'd2)) & win_hi_pri;
        case (busy_sel)
            2'd0: e_busy = (dec_code == 2'd1) & rf_busy;
            2'd1: e_busy = 1'b0;
            2'd2: e_busy = other | rf_busy;
            default: e_busy = other;
        endcase
        e_cca  = (cca_force && dec_code != 2'd2) ? 1'b1 : cca_raw;
        e_tx   = wlan_fwd & wlan_tx_in;
        e_rx   = wlan_fwd & wlan_rx_in;
        e_diag = diag_in;
        if (diag_sel == 2'd1) e_diag[2:0] = {closing, dec_code};
        if (diag_sel == 2'd2) e_diag[5:3] = {closing, dec_code};
    endtask

    task automatic chk(string tag, string nm, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, nm, got, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, "partner_act", 32'(partner_act), 32'(e_act));
        chk(tag, "partner_pri", 32'(partner_pri), 32'(e_pri));
        chk(tag, "a_busy", 32'(a_busy), 32'(e_busy));
        chk(tag, "b_cca", 32'(b_cca), 32'(e_cca));
        chk(tag, "a_wlan_tx", 32'(a_wlan_tx), 32'(e_tx));
        chk(tag, "a_wlan_rx", 32'(a_wlan_rx), 32'(e_rx));
        chk(tag, "diag_out", 32'(diag_out), 32'(e_diag));
    endtask

    // Inputs are already set on a falling edge; cross one rising edge and check.
    task automatic step(string tag);
        model();
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic t_reset();
        @(negedge clk);
        dec_code = 2'd1; act_a = 1; win_hi_pri = 1; rf_busy = 1; cca_raw = 1;
        wlan_fwd = 1; wlan_tx_in = 1; wlan_rx_in = 1; diag_in = 8'hA5;
        @(posedge clk); @(negedge clk);
        e_act = 0; e_pri = 0; e_busy = 0; e_cca = 0; e_tx = 0; e_rx = 0; e_diag = '0;
        check_all("R1");
        rst_n = 1'b1;
        act_a = 0; win_hi_pri = 0; rf_busy = 0; cca_raw = 0; wlan_fwd = 0;
        wlan_tx_in = 0; wlan_rx_in = 0; diag_in = '0; dec_code = 2'd0;
    endtask

    task automatic t_act_modes();
        for (int m = 0; m < 2; m++)
            for (int d = 0; d < 4; d++)
                for (int a = 0; a < 4; a++) begin
                    act_mode = m[0]; dec_code = d[1:0]; {act_a, act_b} = a[1:0];
                    step(m == 0 ? "R2" : "R3");
                end
        act_mode = 0; act_a = 0; act_b = 0;
    endtask

    task automatic t_pri();
        for (int d = 0; d < 4; d++)
            for (int h = 0; h < 2; h++) begin
                dec_code = d[1:0]; win_hi_pri = h[0];
                step("R4");
            end
        win_hi_pri = 0;
    endtask

    task automatic t_busy();
        for (int s = 0; s < 4; s++)
            for (int d = 0; d < 4; d++)
                for (int r = 0; r < 2; r++) begin
                    busy_sel = s[1:0]; dec_code = d[1:0]; rf_busy = r[0];
                    step("R5");
                end
        busy_sel = 0; rf_busy = 0;
    endtask

    task automatic t_cca();
        for (int f = 0; f < 2; f++)
            for (int d = 0; d < 4; d++)
                for (int c = 0; c < 2; c++) begin
                    cca_force = f[0]; dec_code = d[1:0]; cca_raw = c[0];
                    step("R6");
                end
        cca_force = 0; cca_raw = 0;
    endtask

    task automatic t_wlan();
        for (int f = 0; f < 2; f++)
            for (int v = 0; v < 4; v++) begin
                wlan_fwd = f[0]; {wlan_tx_in, wlan_rx_in} = v[1:0];
                step("R7");
            end
        wlan_fwd = 0; wlan_tx_in = 0; wlan_rx_in = 0;
    endtask

    task automatic t_diag();
        for (int s = 0; s < 4; s++)
            for (int d = 0; d < 4; d++)
                for (int c = 0; c < 2; c++) begin
                    diag_sel = s[1:0]; dec_code = d[1:0]; closing = c[0];
                    diag_in = (d[0] ^ c[0]) ? 8'h5A : 8'hC3;
                    step(s == 1 ? "R8" : "R9");
                end
        diag_sel = 0; closing = 0; diag_in = '0;
    endtask

    task automatic t_latency();
        dec_code = 2'd1; act_a = 1; win_hi_pri = 1; busy_sel = 0; rf_busy = 1;
        wlan_fwd = 1; wlan_tx_in = 1; diag_sel = 1; diag_in = 8'hF0;
        step("R10");
        // Change every input mid-cycle; outputs must hold until the next edge.
        dec_code = 2'd3; act_a = 0; win_hi_pri = 0; rf_busy = 0;
        wlan_tx_in = 0; diag_in = 8'h0F;
        #1;
        check_all("R10");
        step("R10");
        dec_code = 0; busy_sel = 0; wlan_fwd = 0; diag_sel = 0; diag_in = '0;
    endtask

    initial begin
        #(4 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_act_modes();
        t_pri();
        t_busy();
        t_cca();
        t_wlan();
        t_diag();
        t_latency();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule